// File: doc/BRIEF.md
# PATA PIO and Multiword DMA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel for PIO and multiword DMA cycles. A 32-bit timing word is written through a simple load port. When a transfer request is accepted, the block takes a snapshot of that word. The snapshot sets the length of each phase of the transfer: an optional setup phase, the strobe-active phase and the strobe-inactive phase. Data accesses and task-file register accesses each have their own active, inactive and setup fields. The request flag that picks between them is latched at acceptance.

A controller issues one request per bus cycle. It marks the first cycle of a burst so that the setup phase is applied only there, and it waits for `done` (or for `busy` to fall) before it issues the next request. The timing word also holds the mode-enable bits and the Ultra DMA cycle fields. This block only stores those fields and shows them on its outputs.

Top module: `pata_strobe_gen`

## Requirements
- R1: While reset is asserted, and right after it, `rd_n` and `wr_n` are high, `busy`, `done`, `bus_rdy` and `strobe_active` are low, and every mode output is zero.
- R2: For a data access, the active phase lasts (timing word bits 8:4) + 1 clock cycles.
- R3: For a data access, the inactive phase lasts (bits 3:0) + 1 clock cycles.
- R4: For a task-file register access (`req_reg`=1), the active phase lasts (bits 17:13) + 1 cycles and the inactive phase lasts (bits 12:9) + 1 cycles.
- R5: A request with `req_first`=1 inserts a setup phase before the active phase. For data it lasts (bits 24:22) + 1 cycles and for register access (bits 27:25) + 1 cycles. With `req_first`=0 there is no setup phase.
- R6: During the active phase, `wr_n` is low for a write (`req_write`=1) and `rd_n` is low for a read. Both strobes are high in every other phase, and they are never low together.
- R7: `strobe_active` is high exactly during the active phase. `bus_rdy` is a one-cycle pulse in the first active cycle.
- R8: `busy` goes high in the cycle after acceptance and stays high through the last inactive cycle. `done` is high for exactly that last inactive cycle. `busy` is low in the next cycle.
- R9: A request presented while `busy` is high is ignored: it changes neither the running transfer nor what follows.
- R10: A timing word written during a transfer does not change that transfer. It applies from the next accepted request.
- R11: The stored word drives `udma_en` (bit 28), `dma_en` (bit 29), `pio_master` (bit 30), `fifo_en` (bit 31), `udma_cycles` (bits 20:18) and `udma_clk2x` (bit 21), from the cycle after `cfg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load `cfg_word` into the timing register |
| cfg_word | input | 32 | Timing word |
| req_valid | input | 1 | Transfer request, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = task-file register access, 0 = data access |
| req_first | input | 1 | First cycle of a burst; applies the setup phase |
| busy | output | 1 | Transfer in progress |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_active | output | 1 | High during the active phase |
| bus_rdy | output | 1 | One-cycle pulse at the start of the active phase |
| done | output | 1 | One-cycle pulse in the last inactive cycle |
| udma_en | output | 1 | Stored Ultra DMA enable |
| dma_en | output | 1 | Stored DMA enable |
| pio_master | output | 1 | Stored bus-master-during-PIO bit |
| fifo_en | output | 1 | Stored PIO FIFO enable |
| udma_cycles | output | 3 | Stored Ultra DMA cycle count |
| udma_clk2x | output | 1 | Stored Ultra DMA doubled-clock select |

## Verification
The bench runs reads and writes on both the data fields and the register fields, with and without the first-cycle setup. In the timing word, every field of one access kind differs from its counterpart of the other kind, so a swap of fields or a decode of the wrong bits shows up as a wrong phase length. All-zero fields test the one-cycle minimum and maximum fields test the widest counts. Two further patterns separate a design that re-reads the live word from one that uses the snapshot: a request pulsed mid-transfer with the opposite flags, and a word rewritten mid-transfer.

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_word,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_reg,
  input  logic        req_first,
  output logic        busy,
  output logic        rd_n,
  output logic        wr_n,
  output logic        strobe_active,
  output logic        bus_rdy,
  output logic        done,
  output logic        udma_en,
  output logic        dma_en,
  output logic        pio_master,
  output logic        fifo_en,
  output logic [2:0]  udma_cycles,
  output logic        udma_clk2x
);
  localparam int CW = 5;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_INACT} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [31:0]   tw, snap;
  logic          wr_q, reg_q;

  wire accept = (ph == S_IDLE) && req_valid;

  wire [CW-1:0] act_len   = reg_q ? snap[17:13] : snap[8:4];
  wire [CW-1:0] inact_len = reg_q ? {1'b0, snap[12:9]} : {1'b0, snap[3:0]};
  wire [CW-1:0] act_new   = req_reg ? tw[17:13] : tw[8:4];
  wire [CW-1:0] setup_new = req_reg ? {2'b0, tw[27:25]} : {2'b0, tw[24:22]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tw <= '0;
    else if (cfg_we) tw <= cfg_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= S_IDLE;
      cnt   <= '0;
      snap  <= '0;
      wr_q  <= 1'b0;
      reg_q <= 1'b0;
    end else begin
      case (ph)
        S_IDLE: if (accept) begin
          snap  <= tw;
          wr_q  <= req_write;
          reg_q <= req_reg;
          if (req_first) begin
            ph  <= S_SETUP;
            cnt <= setup_new;
          end else begin
            ph  <= S_ACT;
            cnt <= act_new;
          end
        end
        S_SETUP: if (cnt == '0) begin
          ph  <= S_ACT;
          cnt <= act_len;
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          ph  <= S_INACT;
          cnt <= inact_len;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy          = (ph != S_IDLE);
  assign strobe_active = (ph == S_ACT);
  assign bus_rdy       = strobe_active && (cnt == act_len);
  assign done          = (ph == S_INACT) && (cnt == '0);
  assign rd_n          = !(strobe_active && !wr_q);
  assign wr_n          = !(strobe_active && wr_q);

  assign udma_cycles = tw[20:18];
  assign udma_clk2x  = tw[21];
  assign udma_en     = tw[28];
  assign dma_en      = tw[29];
  assign pio_master  = tw[30];
  assign fifo_en     = tw[31];
endmodule

// File: rtl/pata_strobe_gen_chk.sv
module pata_strobe_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_word,
  input logic        busy,
  input logic        rd_n,
  input logic        wr_n,
  input logic        strobe_active,
  input logic        bus_rdy,
  input logic        done,
  input logic        udma_en,
  input logic        fifo_en
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> (rd_n && wr_n && !busy && !done));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));

  assert_strobe_phase_R6: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> strobe_active);

  assert_dir_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_active && $past(strobe_active)) |-> ($stable(rd_n) && $stable(wr_n)));

  assert_rdy_in_active_R7: assert property (@(posedge clk) disable iff (!rst_n) bus_rdy |-> strobe_active);

  assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n) bus_rdy |=> !bus_rdy);

  assert_rdy_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n) $rose(strobe_active) |-> bus_rdy);

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy && !strobe_active));

  assert_done_idle_next_R8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);

  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));

  assert_mode_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (udma_en == $past(cfg_word[28]) && fifo_en == $past(cfg_word[31])));
endmodule

bind pata_strobe_gen pata_strobe_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
  .busy(busy), .rd_n(rd_n), .wr_n(wr_n), .strobe_active(strobe_active),
  .bus_rdy(bus_rdy), .done(done), .udma_en(udma_en), .fifo_en(fifo_en)
);

// File: tb/pata_strobe_gen_tb_top.sv
module pata_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_word = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_reg = 1'b0, req_first = 1'b0;
  logic busy, rd_n, wr_n, strobe_active, bus_rdy, done;
  logic udma_en, dma_en, pio_master, fifo_en, udma_clk2x;
  logic [2:0] udma_cycles;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pata_strobe_gen dut_i (.*);

  // behavioural reference: remaining cycles per phase
  int m_rs, m_ra, m_ri, m_alen;
  bit m_wr;
  logic [31:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_ra = 0; m_ri = 0; m_alen = 0; m_wr = 0; m_word = '0;
    end else begin
      if (m_rs > 0) m_rs--;
      else if (m_ra > 0) m_ra--;
      else if (m_ri > 0) m_ri--;
      else if (req_valid) begin
        m_wr   = req_write;
        m_alen = req_reg ? int'(m_word[17:13]) + 1 : int'(m_word[8:4]) + 1;
        m_ri   = req_reg ? int'(m_word[12:9]) + 1  : int'(m_word[3:0]) + 1;
        m_ra   = m_alen;
        m_rs   = !req_first ? 0 : (req_reg ? int'(m_word[27:25]) + 1 : int'(m_word[24:22]) + 1);
      end
      if (cfg_we) m_word = cfg_word;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit e_busy, e_act;
    e_busy = (m_rs + m_ra + m_ri) != 0;
    e_act  = (m_rs == 0) && (m_ra > 0);
    chk(busy == e_busy, "R8", "busy", busy, e_busy);
    chk(done == (m_rs == 0 && m_ra == 0 && m_ri == 1), "R8", "done", done, (m_rs == 0 && m_ra == 0 && m_ri == 1));
    chk(strobe_active == e_act, "R7", "strobe_active", strobe_active, e_act);
    chk(bus_rdy == (e_act && m_ra == m_alen), "R7", "bus_rdy", bus_rdy, (e_act && m_ra == m_alen));
    chk(rd_n == !(e_act && !m_wr), "R6", "rd_n", rd_n, !(e_act && !m_wr));
    chk(wr_n == !(e_act && m_wr), "R6", "wr_n", wr_n, !(e_act && m_wr));
    chk({fifo_en, pio_master, dma_en, udma_en, udma_clk2x, udma_cycles} ==
        {m_word[31:28], m_word[21:18]}, "R11", "mode outputs",
        {fifo_en, pio_master, dma_en, udma_en, udma_clk2x, udma_cycles}, {m_word[31:28], m_word[21:18]});
  end

  function automatic logic [31:0] mk(int di, int da, int ri, int ra, int ds, int rs, int uc, bit u2, logic [3:0] md);
    logic [31:0] w;
    w = '0;
    w[3:0] = di[3:0]; w[8:4] = da[4:0]; w[12:9] = ri[3:0]; w[17:13] = ra[4:0];
    w[20:18] = uc[2:0]; w[21] = u2; w[24:22] = ds[2:0]; w[27:25] = rs[2:0]; w[31:28] = md;
    return w;
  endfunction

  task automatic load(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_word = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one request; measures phase lengths at the ports
  task automatic xfer(input bit wr, input bit rg, input bit first, input bit poke_req,
                      input bit poke_cfg, input logic [31:0] ncfg,
                      input int es, input int ea, input int ei, input string ctx);
    int ns = 0, na = 0, ni = 0, n = 0;
    bit seen_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = rg; req_first = first;
    @(negedge clk);
    req_valid = 1'b0;
    while (!seen_done && n < 200) begin
      if (strobe_active) na++;
      else if (na == 0) ns++;
      else ni++;
      if (done) seen_done = 1;
      if (n == 1 && poke_req) begin
        req_valid = 1'b1; req_write = !wr; req_reg = !rg; req_first = !first;
      end else if (n == 1 && poke_cfg) begin
        cfg_we = 1'b1; cfg_word = ncfg;
      end else begin
        req_valid = 1'b0; cfg_we = 1'b0;
      end
      n++;
      if (!seen_done) @(negedge clk);
    end
    req_valid = 1'b0; cfg_we = 1'b0;
    chk(ns == es, "R5", {ctx, " setup cycles"}, ns, es);
    chk(na == ea, rg ? "R4" : "R2", {ctx, " active cycles"}, na, ea);
    chk(ni == ei, rg ? "R4" : "R3", {ctx, " inactive cycles"}, ni, ei);
    @(negedge clk);
    chk(!busy, "R8", {ctx, " idle after done"}, busy, 0);
  endtask

  initial begin
    logic [31:0] w1, w2;
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !busy && !done && !bus_rdy && !strobe_active, "R1", "reset outputs", {rd_n, wr_n, busy, done}, 4'b1100);
    chk({udma_en, dma_en, pio_master, fifo_en, udma_cycles, udma_clk2x} == 0, "R1", "reset modes", udma_cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !busy, "R1", "after reset", {rd_n, wr_n, busy}, 3'b110);

    w1 = mk(2, 3, 1, 4, 2, 1, 5, 1'b1, 4'b0101);
    load(w1);
    chk(udma_en && !dma_en && pio_master && !fifo_en && udma_cycles == 3'd5 && udma_clk2x, "R11", "mode fields", udma_cycles, 5);

    xfer(0, 0, 1, 0, 0, '0, 3, 4, 3, "R2 data read first");
    xfer(1, 0, 0, 0, 0, '0, 0, 4, 3, "R3 data write");
    xfer(1, 1, 1, 0, 0, '0, 2, 5, 2, "R4 reg write first");
    xfer(0, 1, 0, 0, 0, '0, 0, 5, 2, "R6 reg read");

    xfer(1, 0, 0, 1, 0, '0, 0, 4, 3, "R9 poked while busy");
    chk(!busy && rd_n && wr_n, "R9", "no extra transfer", busy, 0);

    w2 = mk(0, 0, 0, 0, 0, 0, 2, 1'b0, 4'b1010);
    xfer(0, 0, 1, 0, 1, w2, 3, 4, 3, "R10 word changed mid-transfer");
    chk(fifo_en && !udma_en && udma_cycles == 3'd2, "R11", "new mode fields", udma_cycles, 2);
    xfer(0, 0, 1, 0, 0, '0, 1, 1, 1, "R10 new word applies");
    xfer(1, 1, 1, 0, 0, '0, 1, 1, 1, "R5 reg minimum");

    load(mk(15, 31, 15, 31, 7, 7, 7, 1'b1, 4'b1111));
    xfer(0, 0, 1, 0, 0, '0, 8, 32, 16, "R2 data maximum");
    xfer(1, 1, 1, 0, 0, '0, 8, 32, 16, "R4 reg maximum");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule